// File: doc/BRIEF.md
# Receive Guard and No-Response Timers

This block decides when a reader's receive decoders may run, and whether a tag answered during an anticollision slot. It has two countdown timers, and each one runs on its own timebase.

The guard timer starts on the end-of-transmit strobe. While it runs, the decoder reset output stays asserted, so ringing on the antenna after transmission cannot be decoded as data. The no-response timer starts on a slot-start strobe. If the response-start strobe arrives first, the timer stops without any interrupt. If the timer runs out first, the block pulses an interrupt and sets a sticky no-response flag. The flag stays set until the status-clear input is pulsed.

Each timer takes its reload value from its own register. Writing the protocol select loads both registers with that protocol's default values. Any tuning write to a timer register must therefore come after the protocol write. A register value of zero disables its timer.

Top module: `rx_wait_timers`

## Requirements
- R1: After reset, all outputs are low. The guard register holds 4 steps and the no-response register holds 2 steps, which are the protocol-0 defaults.
- R2: A `tx_done` pulse with guard value G≠0 holds `dec_rst` high for exactly G×FINE_DIV cycles, starting in the cycle after the pulse. A new `tx_done` while the guard runs restarts the full interval.
- R3: A timer whose register holds zero never starts. With G=0 there is no `dec_rst`. With N=0 there is no `nresp_busy`, no `irq` and no flag.
- R4: A `slot_begin` pulse with value N≠0 makes `nresp_busy` high for N×COARSE_DIV cycles. In the cycle after busy falls, `irq` and `nresp_flag` are both high.
- R5: A `resp_begin` pulse while the timer is busy stops it in the next cycle and raises no `irq`. This also holds when the pulse lands on the expiry edge.
- R6: A `slot_begin` pulse while the timer is busy restarts the full N×COARSE_DIV interval, and only one `irq` follows.
- R7: A protocol write with select p loads the guard register with 4+3p and the no-response register with 2+p.
- R8: When a protocol write and a timer register write happen in the same cycle, the protocol default wins. A timer register write made after the protocol write takes effect.
- R9: `stat_clr` clears `nresp_flag`. An expiry in the same cycle as the clear leaves the flag set.
- R10: `irq` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proto_wr | input | 1 | Protocol select write strobe |
| proto_sel | input | PROTO_W | Protocol number written |
| guard_wr | input | 1 | Guard register write strobe |
| guard_wdata | input | GUARD_W | Guard steps (fine timebase) |
| nresp_wr | input | 1 | No-response register write strobe |
| nresp_wdata | input | NRESP_W | No-response steps (coarse timebase) |
| tx_done | input | 1 | End-of-transmit strobe |
| slot_begin | input | 1 | Anticollision slot start strobe |
| resp_begin | input | 1 | Tag response start strobe |
| stat_clr | input | 1 | Clears the no-response flag |
| dec_rst | output | 1 | Holds receive decoders in reset |
| irq | output | 1 | No-response interrupt pulse |
| nresp_flag | output | 1 | Sticky no-response status |
| nresp_busy | output | 1 | No-response timer running |

## Verification
Both timers are swept over every small register value, including zero. Each measured interval is compared with value×divider, which separates errors in the divider, off-by-one errors in the count and a broken zero-disable. The no-response timer is also driven with the response strobe in mid-interval, with the response strobe exactly on the expiry edge, and with a second slot start part-way through. These cases tell a correct stop-versus-expire priority from one that is wrong. A sweep over all protocols, plus a write made in the same cycle as a protocol write, shows whether the presets and their priority are correct.

// File: rtl/rxt_pkg.sv
package rxt_pkg;

  // Per-protocol reload presets, in timer steps.
  function automatic int unsigned guard_default(input int unsigned proto);
    return 4 + 3 * proto;
  endfunction

  function automatic int unsigned nresp_default(input int unsigned proto);
    return 2 + proto;
  endfunction

  // Interval in clock cycles for a step count and a divider.
  function automatic int unsigned interval_cycles(input int unsigned steps,
                                                  input int unsigned div);
    return steps * div;
  endfunction

endpackage

// File: rtl/rxt_prescaler.sv
module rxt_prescaler #(
  parameter int unsigned DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = en;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (restart)   cnt <= '0;
        else if (en)        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end

      assign tick = en && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/rxt_countdown.sv
module rxt_countdown #(
  parameter int unsigned W   = 8,
  parameter int unsigned DIV = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] load_val,
  output logic         active,
  output logic         expire
);
  logic [W-1:0] remain;
  logic         tick;

  rxt_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .en      (active),
    .tick    (tick)
  );

  // Start has priority over stop; a zero load leaves the timer idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (start) begin
      active <= (load_val != '0);
      remain <= load_val;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && tick) begin
      remain <= remain - 1'b1;
      if (remain == W'(1)) active <= 1'b0;
    end
  end

  assign expire = active && tick && (remain == W'(1)) && !start && !stop;
endmodule

// File: rtl/rxt_cfg_regs.sv
module rxt_cfg_regs
  import rxt_pkg::*;
#(
  parameter int unsigned PROTO_W = 3,
  parameter int unsigned GUARD_W = 8,
  parameter int unsigned NRESP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               proto_wr,
  input  logic [PROTO_W-1:0] proto_sel,
  input  logic               guard_wr,
  input  logic [GUARD_W-1:0] guard_wdata,
  input  logic               nresp_wr,
  input  logic [NRESP_W-1:0] nresp_wdata,
  output logic [GUARD_W-1:0] guard_q,
  output logic [NRESP_W-1:0] nresp_q
);
  localparam logic [GUARD_W-1:0] GUARD_RST = GUARD_W'(guard_default(0));
  localparam logic [NRESP_W-1:0] NRESP_RST = NRESP_W'(nresp_default(0));

  int unsigned proto_idx;
  assign proto_idx = {{(32-PROTO_W){1'b0}}, proto_sel};

  // The protocol preset overrides a tuning write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guard_q <= GUARD_RST;
      nresp_q <= NRESP_RST;
    end else if (proto_wr) begin
      guard_q <= GUARD_W'(guard_default(proto_idx));
      nresp_q <= NRESP_W'(nresp_default(proto_idx));
    end else begin
      if (guard_wr) guard_q <= guard_wdata;
      if (nresp_wr) nresp_q <= nresp_wdata;
    end
  end
endmodule

// File: rtl/rx_wait_timers.sv
module rx_wait_timers #(
  parameter int unsigned PROTO_W    = 3,
  parameter int unsigned GUARD_W    = 8,
  parameter int unsigned NRESP_W    = 8,
  parameter int unsigned FINE_DIV   = 128,
  parameter int unsigned COARSE_DIV = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               proto_wr,
  input  logic [PROTO_W-1:0] proto_sel,
  input  logic               guard_wr,
  input  logic [GUARD_W-1:0] guard_wdata,
  input  logic               nresp_wr,
  input  logic [NRESP_W-1:0] nresp_wdata,
  input  logic               tx_done,
  input  logic               slot_begin,
  input  logic               resp_begin,
  input  logic               stat_clr,
  output logic               dec_rst,
  output logic               irq,
  output logic               nresp_flag,
  output logic               nresp_busy
);
  logic [GUARD_W-1:0] guard_q;
  logic [NRESP_W-1:0] nresp_q;
  logic               guard_expire;
  logic               nr_expire;
  logic               nr_stop;

  rxt_cfg_regs #(
    .PROTO_W(PROTO_W), .GUARD_W(GUARD_W), .NRESP_W(NRESP_W)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .proto_wr    (proto_wr),
    .proto_sel   (proto_sel),
    .guard_wr    (guard_wr),
    .guard_wdata (guard_wdata),
    .nresp_wr    (nresp_wr),
    .nresp_wdata (nresp_wdata),
    .guard_q     (guard_q),
    .nresp_q     (nresp_q)
  );

  rxt_countdown #(.W(GUARD_W), .DIV(FINE_DIV)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tx_done),
    .stop     (1'b0),
    .load_val (guard_q),
    .active   (dec_rst),
    .expire   (guard_expire)
  );

  assign nr_stop = resp_begin;

  rxt_countdown #(.W(NRESP_W), .DIV(COARSE_DIV)) u_nresp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (slot_begin),
    .stop     (nr_stop),
    .load_val (nresp_q),
    .active   (nresp_busy),
    .expire   (nr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      nresp_flag <= 1'b0;
    end else begin
      irq <= nr_expire;
      if (nr_expire)     nresp_flag <= 1'b1;
      else if (stat_clr) nresp_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_wait_timers_chk.sv
module rx_wait_timers_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_done,
  input logic slot_begin,
  input logic resp_begin,
  input logic stat_clr,
  input logic dec_rst,
  input logic irq,
  input logic nresp_flag,
  input logic nresp_busy,
  input logic guard_expire,
  input logic nr_expire
);
  AST_DECRST_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_rst) |-> $past(tx_done)); // R2
  AST_GUARD_END: assert property (@(posedge clk) disable iff (!rst_n)
    guard_expire |=> !dec_rst); // R2
  AST_BUSY_FROM_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nresp_busy) |-> $past(slot_begin)); // R4
  AST_EXPIRE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    nr_expire |=> (irq && nresp_flag && !nresp_busy)); // R4
  AST_RESP_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_begin && !slot_begin) |=> (!irq && !nresp_busy)); // R5
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (nr_expire && stat_clr) |=> nresp_flag); // R9
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !nr_expire) |=> !nresp_flag); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10
endmodule

bind rx_wait_timers rx_wait_timers_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_done      (tx_done),
  .slot_begin   (slot_begin),
  .resp_begin   (resp_begin),
  .stat_clr     (stat_clr),
  .dec_rst      (dec_rst),
  .irq          (irq),
  .nresp_flag   (nresp_flag),
  .nresp_busy   (nresp_busy),
  .guard_expire (guard_expire),
  .nr_expire    (nr_expire)
);

// File: tb/rx_wait_timers_bench.sv
`timescale 1ns/1ps
module rx_wait_timers_bench;
  localparam int PW = 2;
  localparam int GW = 6;
  localparam int NW = 6;
  localparam int FDIV = 4;
  localparam int CDIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proto_wr = 0, guard_wr = 0, nresp_wr = 0;
  logic [PW-1:0] proto_sel = '0;
  logic [GW-1:0] guard_wdata = '0;
  logic [NW-1:0] nresp_wdata = '0;
  logic tx_done = 0, slot_begin = 0, resp_begin = 0, stat_clr = 0;
  logic dec_rst, irq, nresp_flag, nresp_busy;

  int checks = 0;
  int fails = 0;
  int irq_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_wait_timers #(
    .PROTO_W(PW), .GUARD_W(GW), .NRESP_W(NW),
    .FINE_DIV(FDIV), .COARSE_DIV(CDIV)
  ) u_rx_wait_timers (
    .clk(clk), .rst_n(rst_n),
    .proto_wr(proto_wr), .proto_sel(proto_sel),
    .guard_wr(guard_wr), .guard_wdata(guard_wdata),
    .nresp_wr(nresp_wr), .nresp_wdata(nresp_wdata),
    .tx_done(tx_done), .slot_begin(slot_begin),
    .resp_begin(resp_begin), .stat_clr(stat_clr),
    .dec_rst(dec_rst), .irq(irq),
    .nresp_flag(nresp_flag), .nresp_busy(nresp_busy)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tx();
    @(negedge clk) tx_done = 1; @(negedge clk) tx_done = 0;
  endtask
  task automatic pulse_slot();
    @(negedge clk) slot_begin = 1; @(negedge clk) slot_begin = 0;
  endtask
  task automatic pulse_clr();
    @(negedge clk) stat_clr = 1; @(negedge clk) stat_clr = 0;
  endtask
  task automatic wr_guard(input int v);
    @(negedge clk) begin guard_wr = 1; guard_wdata = GW'(v); end
    @(negedge clk) guard_wr = 0;
  endtask
  task automatic wr_nresp(input int v);
    @(negedge clk) begin nresp_wr = 1; nresp_wdata = NW'(v); end
    @(negedge clk) nresp_wr = 0;
  endtask
  task automatic wr_proto(input int p);
    @(negedge clk) begin proto_wr = 1; proto_sel = PW'(p); end
    @(negedge clk) proto_wr = 0;
  endtask

  task automatic len_guard(output int n);
    n = 0;
    while (dec_rst && n < 2000) begin n++; @(negedge clk); end
  endtask
  task automatic len_busy(output int n);
    n = 0;
    while (nresp_busy && n < 2000) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n, i0, fl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 dec_rst", dec_rst, 0);
    check("R1 irq", irq, 0);
    check("R1 flag", nresp_flag, 0);
    check("R1 busy", nresp_busy, 0);
    pulse_tx(); len_guard(n);
    check("R1 guard default", n, 4 * FDIV);
    pulse_slot(); len_busy(n); pulse_clr();
    check("R1 nresp default", n, 2 * CDIV);

    // R2 / R3 guard sweep
    for (int v = 0; v <= 6; v++) begin
      wr_guard(v); pulse_tx(); len_guard(n);
      check(v == 0 ? "R3 guard zero" : "R2 guard length", n, v * FDIV);
    end
    // R2 retrigger
    wr_guard(3); pulse_tx(); repeat (5) @(negedge clk);
    pulse_tx(); len_guard(n);
    check("R2 retrigger", n, 3 * FDIV);

    // R4 / R3 / R9 / R10 no-response sweep
    for (int v = 0; v <= 5; v++) begin
      wr_nresp(v); i0 = irq_seen; pulse_slot(); len_busy(n);
      fl = nresp_flag;
      repeat (3) @(negedge clk);
      check(v == 0 ? "R3 nresp zero" : "R4 nresp length", n, v * CDIV);
      check("R10 irq count", irq_seen - i0, v == 0 ? 0 : 1);
      check("R4 flag", fl, v == 0 ? 0 : 1);
      pulse_clr();
      check("R9 flag cleared", nresp_flag, 0);
    end

    // R5 response mid-interval
    wr_nresp(4); i0 = irq_seen; pulse_slot(); repeat (3) @(negedge clk);
    @(negedge clk) resp_begin = 1; @(negedge clk) resp_begin = 0;
    check("R5 busy stops", nresp_busy, 0);
    repeat (4 * CDIV) @(negedge clk);
    check("R5 no irq", irq_seen - i0, 0);
    check("R5 no flag", nresp_flag, 0);

    // R5 response on the expiry edge
    wr_nresp(2); i0 = irq_seen; pulse_slot();
    repeat (2 * CDIV - 1) @(negedge clk);
    resp_begin = 1; @(negedge clk) resp_begin = 0;
    repeat (4) @(negedge clk);
    check("R5 coincident irq", irq_seen - i0, 0);
    check("R5 coincident flag", nresp_flag, 0);

    // R6 restart
    wr_nresp(3); i0 = irq_seen; pulse_slot(); repeat (5) @(negedge clk);
    pulse_slot(); len_busy(n); repeat (3) @(negedge clk);
    check("R6 restart length", n, 3 * CDIV);
    check("R6 single irq", irq_seen - i0, 1);
    pulse_clr();

    // R7 protocol presets
    for (int p = 0; p < (1 << PW); p++) begin
      wr_proto(p);
      pulse_tx(); len_guard(n);
      check("R7 guard preset", n, (4 + 3 * p) * FDIV);
      pulse_slot(); len_busy(n);
      check("R7 nresp preset", n, (2 + p) * CDIV);
      pulse_clr();
    end

    // R8 same-cycle priority, then later write
    @(negedge clk) begin
      proto_wr = 1; proto_sel = PW'(1); guard_wr = 1; guard_wdata = GW'(2);
      nresp_wr = 1; nresp_wdata = NW'(5);
    end
    @(negedge clk) begin proto_wr = 0; guard_wr = 0; nresp_wr = 0; end
    pulse_tx(); len_guard(n);
    check("R8 guard preset wins", n, 7 * FDIV);
    pulse_slot(); len_busy(n);
    check("R8 nresp preset wins", n, 3 * CDIV);
    pulse_clr();
    wr_guard(2); pulse_tx(); len_guard(n);
    check("R8 tune after preset", n, 2 * FDIV);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule